// File: doc/BRIEF.md
# Peripheral access control gate

The gate sits on the path from a bus master to a group of peripheral address windows. Every request carries an address. The gate matches that address against a map of regions fixed at build time and then takes one of two actions. It passes the request downstream in the same cycle, or it withholds the request and returns a fault response. A fault has three causes: the address lies in no region, the region's peripheral does not exist on this variant, or software has set the region's disable bit.

Software configures the gate through a small word-addressed register port. Three writable disable words hold the gating bits. Several regions may share one bit, for example a timer's common registers and its first channel. Three read-only presence words report which peripherals exist. Three read-only words report the sizes of the on-chip memories in scaled form. Every response, forwarded or faulted, appears exactly one cycle after its request. A faulted response never carries read data.

Top module: `pag_top`

## Requirements
- R1: After reset, all three disable words read 0 and every present region forwards its accesses.
- R2: A request that hits a present region whose disable bit is 0 is forwarded in the same cycle. dn_valid is 1, and dn_addr, dn_write and dn_wdata equal the request. One cycle later rsp_valid=1, rsp_fault=0 and rsp_rdata equals dn_rdata.
- R3: A request that hits a region whose disable bit is 1 is not forwarded (dn_valid=0) and faults.
- R4: A request whose address lies in no region's window [base, base+size) is not forwarded and faults.
- R5: A request that hits a region marked absent faults even when its disable bit is 0.
- R6: Every request produces rsp_valid exactly one cycle later, and no cycle without a request does. A faulted response has rsp_fault=1 and rsp_rdata=0.
- R7: The disable words sit at byte offsets 0x80, 0x84 and 0x88 (word 0 to 2). All 32 bits of each word are writable and read back. A read presents cfg_rvalid=1 and cfg_rdata in the cycle after the request.
- R8: The presence words sit at offsets 0x40, 0x44 and 0x48. A bit is 1 exactly when some present region selects that (word, bit). Writes to these words have no effect. With the default map the values are 0x00400004, 0x00000601 and 0x00000001.
- R9: The size words are read-only. 0x400 gives ROM bytes/256, 0x404 gives flash KiB/4+1, and 0x410 gives RAM bytes/256. The defaults are 0x20, 0x11 and 0x40.
- R10: Every other offset, including any offset whose two low bits are not zero, reads 0 and ignores writes.
- R11: Setting one disable bit blocks every region mapped to that bit and leaves all other regions unaffected.
- R12: A disable-word write in cycle N gates requests from cycle N+1 onward. A request in cycle N uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Register-port request |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rvalid | output | 1 | Read data valid (one cycle after read request) |
| cfg_rdata | output | 32 | Register read data |
| acc_valid | input | 1 | Access request from master |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 32 | Access address |
| acc_wdata | input | 32 | Access write data |
| rsp_valid | output | 1 | Access response valid |
| rsp_fault | output | 1 | Access faulted |
| rsp_rdata | output | 32 | Access read data (zero on fault) |
| dn_valid | output | 1 | Forwarded request to peripherals |
| dn_write | output | 1 | Forwarded write flag |
| dn_addr | output | 32 | Forwarded address |
| dn_wdata | output | 32 | Forwarded write data |
| dn_rdata | input | 32 | Read data from peripherals, one cycle after dn_valid |

## Verification
The checker verifies on every cycle that each request gets exactly one response one cycle later. It also checks that a withheld request always comes back faulted with zero data, that a forwarded one always comes back clean with the peripheral's data, and that register reads are acknowledged on time. Those properties cannot tell whether a given address should have been blocked. The bench scenarios cover that: window edges, absent regions, shared disable bits, the register map contents, the ignored writes to read-only and reserved offsets, and the exact cycle at which a new disable value takes effect.

// File: rtl/pag_pkg.sv
package pag_pkg;

    // Control-word geometry shared by the register file and the decoder.
    localparam int CTRL_W    = 32;
    localparam int NUM_CTRL  = 3;
    localparam int SEL_REG_W = $clog2(NUM_CTRL);
    localparam int SEL_BIT_W = $clog2(CTRL_W);

    // Word indices of the register port (byte offset / 4); decoders depend on them.
    localparam int W_AVAIL = 16;
    localparam int W_DIS   = 32;
    localparam int W_ROM   = 256;
    localparam int W_FLASH = 257;
    localparam int W_RAM   = 260;

    typedef enum logic [2:0] {
        CS_NONE,
        CS_AVAIL,
        CS_DIS,
        CS_ROM,
        CS_FLASH,
        CS_RAM
    } cfg_sel_e;

    typedef struct packed {
        logic valid;
        logic fault;
    } rsp_state_t;

endpackage

// File: rtl/pag_regfile.sv
module pag_regfile
    import pag_pkg::*;
#(
    parameter int          CFG_AW      = 12,
    parameter logic [31:0] ROM_FIELD   = 32'd32,
    parameter logic [31:0] FLASH_FIELD = 32'd17,
    parameter logic [31:0] RAM_FIELD   = 32'd64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_valid,
    input  logic                              cfg_write,
    input  logic [CFG_AW-1:0]                 cfg_addr,
    input  logic [CTRL_W-1:0]                 cfg_wdata,
    input  logic [NUM_CTRL-1:0][CTRL_W-1:0]   avail,
    output logic [NUM_CTRL-1:0][CTRL_W-1:0]   dis,
    output logic                              cfg_rvalid,
    output logic [CTRL_W-1:0]                 cfg_rdata
);

    localparam int WORD_W = CFG_AW - 2;
    localparam logic [WORD_W-1:0] AV_LO  = WORD_W'(W_AVAIL);
    localparam logic [WORD_W-1:0] AV_HI  = WORD_W'(W_AVAIL + NUM_CTRL);
    localparam logic [WORD_W-1:0] DIS_LO = WORD_W'(W_DIS);
    localparam logic [WORD_W-1:0] DIS_HI = WORD_W'(W_DIS + NUM_CTRL);
    localparam logic [WORD_W-1:0] ROM_W  = WORD_W'(W_ROM);
    localparam logic [WORD_W-1:0] FL_W   = WORD_W'(W_FLASH);
    localparam logic [WORD_W-1:0] RAM_W  = WORD_W'(W_RAM);

    typedef struct packed {
        logic [NUM_CTRL-1:0][CTRL_W-1:0] dis;
        logic [CTRL_W-1:0]               rdata;
        logic                            rvalid;
    } rf_state_t;

    rf_state_t         st_d, st_q;
    cfg_sel_e          sel;
    logic [WORD_W-1:0] word;
    logic [SEL_REG_W-1:0] idx;

    // Offset classification
    always_comb begin
        word = cfg_addr[CFG_AW-1:2];
        sel  = CS_NONE;
        idx  = '0;
        if (cfg_addr[1:0] == 2'b00) begin
            if (word >= AV_LO && word < AV_HI) begin
                sel = CS_AVAIL;
                idx = SEL_REG_W'(word - AV_LO);
            end else if (word >= DIS_LO && word < DIS_HI) begin
                sel = CS_DIS;
                idx = SEL_REG_W'(word - DIS_LO);
            end else if (word == ROM_W) begin
                sel = CS_ROM;
            end else if (word == FL_W) begin
                sel = CS_FLASH;
            end else if (word == RAM_W) begin
                sel = CS_RAM;
            end
        end
    end

    // Next-state computation
    always_comb begin
        st_d        = st_q;
        st_d.rvalid = cfg_valid && !cfg_write;
        st_d.rdata  = '0;
        if (cfg_valid && cfg_write && sel == CS_DIS) begin
            st_d.dis[idx] = cfg_wdata;
        end
        if (cfg_valid && !cfg_write) begin
            unique case (sel)
                CS_AVAIL: st_d.rdata = avail[idx];
                CS_DIS:   st_d.rdata = st_q.dis[idx];
                CS_ROM:   st_d.rdata = ROM_FIELD;
                CS_FLASH: st_d.rdata = FLASH_FIELD;
                CS_RAM:   st_d.rdata = RAM_FIELD;
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dis        = st_q.dis;
    assign cfg_rvalid = st_q.rvalid;
    assign cfg_rdata  = st_q.rdata;

endmodule

// File: rtl/pag_decode.sv
module pag_decode
    import pag_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32,
    parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0]    REGION_BASE = '0,
    parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0]    REGION_SIZE = '0,
    parameter logic [NUM_REGIONS-1:0][SEL_REG_W-1:0] REGION_REG  = '0,
    parameter logic [NUM_REGIONS-1:0][SEL_BIT_W-1:0] REGION_BIT  = '0
) (
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [NUM_CTRL-1:0][CTRL_W-1:0]   dis,
    input  logic [NUM_CTRL-1:0][CTRL_W-1:0]   avail,
    output logic                              allow
);

    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

    logic [NUM_REGIONS-1:0] hit;
    logic                   any_hit;
    logic [IDX_W-1:0]       win;
    logic [SEL_REG_W-1:0]   wreg;
    logic [SEL_BIT_W-1:0]   wbit;

    // One window comparator per region
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
        logic [ADDR_W-1:0] off;
        assign off    = addr - REGION_BASE[g];
        assign hit[g] = off < REGION_SIZE[g];
    end

    // Lowest-numbered matching region wins
    always_comb begin
        any_hit = 1'b0;
        win     = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any_hit = 1'b1;
                win     = IDX_W'(i);
            end
        end
    end

    always_comb begin
        wreg  = REGION_REG[win];
        wbit  = REGION_BIT[win];
        allow = any_hit && avail[wreg][wbit] && !dis[wreg][wbit];
    end

endmodule

// File: rtl/pag_resp.sv
module pag_resp
    import pag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              allow,
    input  logic [DATA_W-1:0] dn_rdata,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [DATA_W-1:0] rsp_rdata
);

    rsp_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = req;
        st_d.fault = req && !allow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.valid;
    assign rsp_fault = st_q.fault;
    assign rsp_rdata = (st_q.valid && !st_q.fault) ? dn_rdata : '0;

endmodule

// File: rtl/pag_top.sv
module pag_top
    import pag_pkg::*;
#(
    parameter int CFG_AW      = 12,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int NUM_REGIONS = 8,
    parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] REGION_BASE = {
        32'h4005_0000, 32'h4004_0000, 32'h4003_0000, 32'h4002_0000,
        32'h4001_0200, 32'h4001_0100, 32'h4001_0000, 32'h4000_0000},
    parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] REGION_SIZE = {
        32'h100, 32'h100, 32'h400, 32'h200,
        32'h100, 32'h100, 32'h100, 32'h1000},
    parameter logic [NUM_REGIONS-1:0][SEL_REG_W-1:0] REGION_REG = {
        2'd0, 2'd2, 2'd2, 2'd1, 2'd1, 2'd1, 2'd1, 2'd0},
    parameter logic [NUM_REGIONS-1:0][SEL_BIT_W-1:0] REGION_BIT = {
        5'd22, 5'd12, 5'd0, 5'd0, 5'd10, 5'd9, 5'd9, 5'd2},
    parameter logic [NUM_REGIONS-1:0] REGION_PRESENT = 8'b1011_1111,
    parameter int ROM_BYTES = 8192,
    parameter int FLASH_KB  = 64,
    parameter int RAM_BYTES = 16384
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic              cfg_rvalid,
    output logic [31:0]       cfg_rdata,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              dn_valid,
    output logic              dn_write,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic [DATA_W-1:0] dn_rdata
);

    localparam logic [31:0] ROM_FIELD   = 32'(ROM_BYTES / 256);
    localparam logic [31:0] FLASH_FIELD = 32'(FLASH_KB / 4 + 1);
    localparam logic [31:0] RAM_FIELD   = 32'(RAM_BYTES / 256);

    logic [NUM_CTRL-1:0][CTRL_W-1:0] avail_w;
    logic [NUM_CTRL-1:0][CTRL_W-1:0] dis_w;
    logic                            allow;

    // Presence words follow from the region map
    always_comb begin
        avail_w = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (REGION_PRESENT[i]) begin
                avail_w[REGION_REG[i]][REGION_BIT[i]] = 1'b1;
            end
        end
    end

    pag_regfile #(
        .CFG_AW      (CFG_AW),
        .ROM_FIELD   (ROM_FIELD),
        .FLASH_FIELD (FLASH_FIELD),
        .RAM_FIELD   (RAM_FIELD)
    ) i_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_valid  (cfg_valid),
        .cfg_write  (cfg_write),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .avail      (avail_w),
        .dis        (dis_w),
        .cfg_rvalid (cfg_rvalid),
        .cfg_rdata  (cfg_rdata)
    );

    pag_decode #(
        .NUM_REGIONS (NUM_REGIONS),
        .ADDR_W      (ADDR_W),
        .REGION_BASE (REGION_BASE),
        .REGION_SIZE (REGION_SIZE),
        .REGION_REG  (REGION_REG),
        .REGION_BIT  (REGION_BIT)
    ) i_decode (
        .addr  (acc_addr),
        .dis   (dis_w),
        .avail (avail_w),
        .allow (allow)
    );

    pag_resp #(
        .DATA_W (DATA_W)
    ) i_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (acc_valid),
        .allow     (allow),
        .dn_rdata  (dn_rdata),
        .rsp_valid (rsp_valid),
        .rsp_fault (rsp_fault),
        .rsp_rdata (rsp_rdata)
    );

    assign dn_valid = acc_valid && allow;
    assign dn_write = acc_write && allow;
    assign dn_addr  = acc_addr;
    assign dn_wdata = acc_wdata;

endmodule

// File: rtl/pag_checker.sv
module pag_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_valid,
    input logic              cfg_write,
    input logic              cfg_rvalid,
    input logic              acc_valid,
    input logic              dn_valid,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [DATA_W-1:0] dn_rdata
);

    p_fwd_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> acc_valid);

    p_rsp_follows_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);

    p_no_spurious_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);

    p_blocked_faults_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !dn_valid) |=> (rsp_fault && rsp_rdata == '0));

    p_fwd_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && dn_valid) |=> (!rsp_fault && rsp_rdata == dn_rdata));

    p_read_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_write) |=> cfg_rvalid);

    p_no_stray_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_valid && !cfg_write) |=> !cfg_rvalid);

endmodule

bind pag_top pag_checker #(.DATA_W(DATA_W)) i_pag_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_valid  (cfg_valid),
    .cfg_write  (cfg_write),
    .cfg_rvalid (cfg_rvalid),
    .acc_valid  (acc_valid),
    .dn_valid   (dn_valid),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .rsp_rdata  (rsp_rdata),
    .dn_rdata   (dn_rdata)
);

// File: tb/test_pag_top.sv
module test_pag_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic        cfg_write = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_rvalid;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_rdata;
    logic        dn_valid, dn_write;
    logic [31:0] dn_addr, dn_wdata;
    logic [31:0] dn_rdata;
    logic [31:0] model_rdata = 32'h1111_2222;

    int checks = 0;
    int fails  = 0;

    localparam logic [31:0] RD_XOR = 32'hA5A5_0000;

    always #10 clk = ~clk;

    // Peripheral model: read data is a function of the address, one cycle later
    always_ff @(posedge clk) begin
        if (dn_valid && !dn_write) model_rdata <= dn_addr ^ RD_XOR;
    end
    assign dn_rdata = model_rdata;

    pag_top i_pag_top (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_rdata(rsp_rdata), .dn_valid(dn_valid), .dn_write(dn_write),
        .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_write = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_valid = 1'b0; cfg_write = 1'b0;
    endtask

    task automatic cfg_rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_write = 1'b0; cfg_addr = a;
        @(negedge clk);
        cfg_valid = 1'b0;
        check({tag, " rvalid"}, 32'(cfg_rvalid), 32'd1);
        check({tag, " rdata"}, cfg_rdata, exp);
    endtask

    task automatic access(input string tag, input logic [31:0] a, input logic wr,
                          input logic [31:0] wd, input logic exp_fault);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = wd;
        #1;
        check({tag, " dn_valid"}, 32'(dn_valid), 32'(!exp_fault));
        if (!exp_fault) begin
            check({tag, " dn_addr"}, dn_addr, a);
            check({tag, " dn_write"}, 32'(dn_write), 32'(wr));
            if (wr) check({tag, " dn_wdata"}, dn_wdata, wd);
        end
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        check({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " rsp_fault"}, 32'(rsp_fault), 32'(exp_fault));
        if (exp_fault)  check({tag, " rsp_rdata"}, rsp_rdata, 32'h0);
        else if (!wr)   check({tag, " rsp_rdata"}, rsp_rdata, a ^ RD_XOR);
    endtask

    task automatic t_reset;
        check("R1 rsp idle", 32'(rsp_valid), 32'd0);
        cfg_rd("R1 dis0", 12'h080, 32'h0);
        cfg_rd("R1 dis1", 12'h084, 32'h0);
        cfg_rd("R1 dis2", 12'h088, 32'h0);
        access("R1 region7", 32'h4005_00F0, 1'b0, '0, 1'b0);
        @(negedge clk);
        check("R6 no rsp without req", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_forward;
        access("R2 rd region0", 32'h4000_0010, 1'b0, '0, 1'b0);
        access("R2 rd region4 top", 32'h4002_01FC, 1'b0, '0, 1'b0);
        access("R2 wr region7", 32'h4005_0004, 1'b1, 32'hCAFE_F00D, 1'b0);
        access("R2 rd region5 base", 32'h4003_0000, 1'b0, '0, 1'b0);
    endtask

    task automatic t_unassigned;
        access("R4 below map", 32'h3FFF_FFFC, 1'b0, '0, 1'b1);
        access("R4 past region0", 32'h4000_1000, 1'b0, '0, 1'b1);
        access("R4 past region3", 32'h4001_0300, 1'b1, 32'h5, 1'b1);
        access("R4 past region5", 32'h4003_0400, 1'b0, '0, 1'b1);
    endtask

    task automatic t_absent;
        access("R5 absent region6", 32'h4004_0010, 1'b0, '0, 1'b1);
        cfg_wr(12'h088, 32'h0);
        access("R5 absent with dis 0", 32'h4004_0000, 1'b0, '0, 1'b1);
    endtask

    task automatic t_avail;
        cfg_rd("R8 avail0", 12'h040, 32'h0040_0004);
        cfg_rd("R8 avail1", 12'h044, 32'h0000_0601);
        cfg_rd("R8 avail2", 12'h048, 32'h0000_0001);
        cfg_wr(12'h044, 32'hFFFF_FFFF);
        cfg_rd("R8 avail1 after write", 12'h044, 32'h0000_0601);
    endtask

    task automatic t_sizes;
        cfg_rd("R9 rom", 12'h400, 32'h20);
        cfg_rd("R9 flash", 12'h404, 32'h11);
        cfg_rd("R9 ram", 12'h410, 32'h40);
        cfg_wr(12'h400, 32'h1234);
        cfg_rd("R9 rom after write", 12'h400, 32'h20);
    endtask

    task automatic t_reserved;
        cfg_rd("R10 word 19", 12'h04C, 32'h0);
        cfg_rd("R10 word 35", 12'h08C, 32'h0);
        cfg_rd("R10 0x200", 12'h200, 32'h0);
        cfg_wr(12'h08C, 32'hFFFF_FFFF);
        cfg_wr(12'h081, 32'hFFFF_FFFF);
        cfg_rd("R10 dis0 untouched", 12'h080, 32'h0);
        cfg_rd("R10 dis1 untouched", 12'h084, 32'h0);
        cfg_rd("R10 dis2 untouched", 12'h088, 32'h0);
        cfg_rd("R10 unaligned read", 12'h042, 32'h0);
        access("R10 gating unchanged", 32'h4001_0200, 1'b0, '0, 1'b0);
    endtask

    task automatic t_disable_rw;
        cfg_wr(12'h080, 32'hDEAD_BEEF);
        cfg_wr(12'h088, 32'h1234_5678);
        cfg_rd("R7 dis0", 12'h080, 32'hDEAD_BEEF);
        cfg_rd("R7 dis2", 12'h088, 32'h1234_5678);
        access("R3 region0 bit2 set", 32'h4000_0100, 1'b0, '0, 1'b1);
        access("R3 region7 bit22 clear", 32'h4005_0008, 1'b0, '0, 1'b0);
        cfg_wr(12'h080, 32'h0);
        cfg_wr(12'h088, 32'h0);
        access("R3 region0 reenabled", 32'h4000_0100, 1'b0, '0, 1'b0);
    endtask

    task automatic t_shared;
        cfg_wr(12'h084, 32'h0000_0200);
        cfg_rd("R7 dis1", 12'h084, 32'h0000_0200);
        access("R11 kernel blocked", 32'h4001_0000, 1'b0, '0, 1'b1);
        access("R11 chan0 blocked", 32'h4001_0180, 1'b1, 32'h7, 1'b1);
        access("R11 chan1 open", 32'h4001_0200, 1'b0, '0, 1'b0);
        access("R11 region4 open", 32'h4002_0000, 1'b0, '0, 1'b0);
        cfg_wr(12'h084, 32'h0);
        access("R11 kernel reenabled", 32'h4001_0004, 1'b0, '0, 1'b0);
    endtask

    task automatic t_update_timing;
        @(negedge clk);
        cfg_valid = 1'b1; cfg_write = 1'b1; cfg_addr = 12'h080; cfg_wdata = 32'h4;
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 32'h4000_0020;
        #1;
        check("R12 same-cycle request forwarded", 32'(dn_valid), 32'd1);
        @(negedge clk);
        cfg_valid = 1'b0; cfg_write = 1'b0;
        check("R12 old setting no fault", 32'(rsp_fault), 32'd0);
        check("R12 old setting rdata", rsp_rdata, 32'h4000_0020 ^ RD_XOR);
        #1;
        check("R12 next request withheld", 32'(dn_valid), 32'd0);
        @(negedge clk);
        acc_valid = 1'b0;
        check("R12 next request faults", 32'(rsp_fault), 32'd1);
        check("R12 next request valid", 32'(rsp_valid), 32'd1);
        cfg_wr(12'h080, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_forward;
        t_unassigned;
        t_absent;
        t_avail;
        t_sizes;
        t_reserved;
        t_disable_rw;
        t_shared;
        t_update_timing;
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule